// File: doc/BRIEF.md
# Timer Gate and Speaker Control Port

This block is an 8-bit system control register that sits beside a programmable interval timer. Software writes it to open or close the gate input of timer channel 2 and to switch the speaker on or off. Reading it returns the gate and speaker settings, the live output of channel 2, and a refresh bit that flips at a fixed rate no matter what any counter is doing.

When software raises the gate from 0 to 1, the block sends channel 2 a one-cycle restart request. It only does this if channel 2 is in a mode that is triggered by its gate. The channel's counting logic is a neighbour block: it supplies its mode code and its output to this block, and it receives the restart pulse back.

The write side is a valid/ready stream. `wr_ready` is tied high, so the block never applies back-pressure, and a write is taken in every cycle where `wr_valid` is high. The read side is plain combinational status.

Top module: `sysctl_port`

## Requirements
- R1: A write that is accepted copies data bit 0 into the channel 2 gate and data bit 1 into the speaker enable. Data bits 2 to 7 have no effect on anything.
- R2: The read data has this layout: bit 0 is the gate, bit 1 is the speaker enable, bit 4 is the refresh bit, and bit 5 mirrors `ch2_out`. Bits 2, 3, 6 and 7 always read 0.
- R3: Channel 2's mode is a 3-bit code, `ch2_mode`. If this code is 1, 2, 3 or 5, a write that takes the gate from 0 to 1 raises `ch2_restart` for exactly one cycle, in the cycle after the write.
- R4: If `ch2_mode` is 0 or 4, a write that raises the gate updates the gate but never raises `ch2_restart`.
- R5: `ch2_restart` stays low for any write that does not take the gate from 0 to 1. This covers writing 1 while the gate is already 1, and writing 0.
- R6: If `ch2_mode` is 6 or 7, a write changes neither the gate nor the speaker enable, and it raises no restart.
- R7: The refresh bit inverts once every `REFRESH_CYCLES` clock cycles, counted from the release of reset, whether or not any writes take place.
- R8: While reset is held, and right after it is released, the gate, the speaker enable and the refresh bit are all 0, and `ch2_restart` is low.
- R9: `wr_ready` is high in every cycle, so every write with `wr_valid` high is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read value of the port |
| ch2_mode | input | 3 | Mode code programmed in channel 2 |
| ch2_out | input | 1 | Live output of channel 2 |
| ch2_restart | output | 1 | One-cycle request to restart channel 2's count |
| ch2_gate | output | 1 | Gate level driven to channel 2 |
| spk_enable | output | 1 | Speaker enable |

## Verification
The gate, the speaker enable and `ch2_restart` all come from registers. They change on the clock edge that accepts the write, so the bench drives each write on a falling edge and checks them on the next falling edge. It then checks once more, one cycle later, that the restart pulse has dropped. The read value is combinational, so `ch2_out` shows up in bit 5 in the same cycle it is driven. The refresh bit changes on every `REFRESH_CYCLES`-th edge after reset. The bench therefore counts falling edges between changes of bit 4, and it masks bit 4 out of every other read comparison.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;

  // bit positions of the port, on both the read and the write side
  localparam int GATE_BIT = 0;
  localparam int SPK_BIT  = 1;
  localparam int RFSH_BIT = 4;
  localparam int OUT_BIT  = 5;

  typedef enum logic [MODE_W-1:0] {
    M_TERM_INT   = 3'd0,
    M_ONE_SHOT   = 3'd1,
    M_RATE       = 3'd2,
    M_SQUARE     = 3'd3,
    M_SW_STROBE  = 3'd4,
    M_HW_STROBE  = 3'd5,
    M_BAD6       = 3'd6,
    M_BAD7       = 3'd7
  } ch_mode_e;

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return (m <= 3'd5);
  endfunction

  function automatic logic mode_gate_trig(input logic [MODE_W-1:0] m);
    unique case (ch_mode_e'(m))
      M_ONE_SHOT, M_RATE, M_SQUARE, M_HW_STROBE: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_wreg.sv
module sysctl_wreg
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] mode,
  output logic              gate_q,
  output logic              spk_q,
  output logic              gate_nxt,
  output logic              upd
);
  assign upd      = wr_fire && mode_valid(mode);
  assign gate_nxt = wr_data[GATE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (upd) begin
      gate_q <= wr_data[GATE_BIT];
      spk_q  <= wr_data[SPK_BIT];
    end
  end
endmodule

// File: rtl/sysctl_gate_edge.sv
module sysctl_gate_edge
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              gate_cur,
  input  logic              gate_nxt,
  input  logic [MODE_W-1:0] mode,
  output logic              restart
);
  logic rise;
  assign rise = upd && gate_nxt && !gate_cur && mode_gate_trig(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) restart <= 1'b0;
    else        restart <= rise;
  end
endmodule

// File: rtl/sysctl_refresh.sv
module sysctl_refresh #(
  parameter int PERIOD = 750
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      tog <= ~tog;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              gate,
  input  logic              spk,
  input  logic              rfsh,
  input  logic              out,
  output logic [DATA_W-1:0] rd
);
  always_comb begin
    rd           = '0;
    rd[GATE_BIT] = gate;
    rd[SPK_BIT]  = spk;
    rd[RFSH_BIT] = rfsh;
    rd[OUT_BIT]  = out;
  end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int REFRESH_CYCLES = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [MODE_W-1:0] ch2_mode,
  input  logic              ch2_out,
  output logic              ch2_restart,
  output logic              ch2_gate,
  output logic              spk_enable
);
  logic fire, upd, gate_nxt, rfsh;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  sysctl_wreg u_wreg (
    .clk(clk), .rst_n(rst_n), .wr_fire(fire), .wr_data(wr_data),
    .mode(ch2_mode), .gate_q(ch2_gate), .spk_q(spk_enable),
    .gate_nxt(gate_nxt), .upd(upd)
  );

  sysctl_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .upd(upd), .gate_cur(ch2_gate),
    .gate_nxt(gate_nxt), .mode(ch2_mode), .restart(ch2_restart)
  );

  sysctl_refresh #(.PERIOD(REFRESH_CYCLES)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .tog(rfsh)
  );

  sysctl_rdmux u_mux (
    .gate(ch2_gate), .spk(spk_enable), .rfsh(rfsh), .out(ch2_out),
    .rd(rd_data)
  );
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
  parameter int REFRESH_CYCLES = 750
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [2:0] ch2_mode,
  input logic       ch2_restart,
  input logic       ch2_gate,
  input logic       spk_enable
);
  localparam int CW = $clog2(REFRESH_CYCLES + 1) + 1;
  logic [CW-1:0] since;
  logic          prev_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since  <= '0;
      prev_r <= 1'b0;
    end else begin
      prev_r <= rd_data[4];
      if (rd_data[4] != prev_r) since <= CW'(1);
      else                      since <= since + 1'b1;
    end
  end

  // R3
  restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_restart |-> ($past(wr_valid) && $past(wr_data[0]) && !$past(ch2_gate)
                     && ($past(ch2_mode) inside {3'd1, 3'd2, 3'd3, 3'd5})));
  // R3
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_restart |=> !ch2_restart);
  // R6
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ch2_mode > 3'd5) |=> ($stable(ch2_gate) && $stable(spk_enable) && !ch2_restart));
  // R1
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ch2_mode <= 3'd5) |=> (ch2_gate == $past(wr_data[0]) && spk_enable == $past(wr_data[1])));
  // R2
  rd_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:6] == 2'b00) && (rd_data[3:2] == 2'b00) && rd_data[0] == ch2_gate && rd_data[1] == spk_enable);
  // R7
  rfsh_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] != prev_r) |-> (since == CW'(REFRESH_CYCLES)));
  // R7
  rfsh_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since <= CW'(REFRESH_CYCLES));
  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

bind sysctl_port sysctl_port_chk #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_data(rd_data), .ch2_mode(ch2_mode),
  .ch2_restart(ch2_restart), .ch2_gate(ch2_gate), .spk_enable(spk_enable)
);

// File: tb/sysctl_port_test.sv
module sysctl_port_test;
  localparam int P = 750;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] ch2_mode = '0;
  logic       ch2_out = 1'b0;
  logic       ch2_restart, ch2_gate, spk_enable;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysctl_port #(.REFRESH_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .ch2_mode(ch2_mode),
    .ch2_out(ch2_out), .ch2_restart(ch2_restart), .ch2_gate(ch2_gate),
    .spk_enable(spk_enable)
  );

  // {mode[2:0], wdata[7:0], out, exp_rd_masked[7:0], exp_restart}
  localparam logic [20:0] VEC [15] = '{
    {3'd2, 8'h01, 1'b0, 8'h01, 1'b1},  // R3 rising, mode 2
    {3'd2, 8'h01, 1'b1, 8'h21, 1'b0},  // R5 no edge, R2 out bit
    {3'd2, 8'hFC, 1'b0, 8'h00, 1'b0},  // R1 upper bits dropped, R5 write 0
    {3'd0, 8'h03, 1'b1, 8'h23, 1'b0},  // R4 mode 0
    {3'd0, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd4, 8'h01, 1'b0, 8'h01, 1'b0},  // R4 mode 4
    {3'd4, 8'h02, 1'b0, 8'h02, 1'b0},  // R1 speaker only
    {3'd1, 8'h03, 1'b0, 8'h03, 1'b1},  // R3 mode 1
    {3'd3, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd3, 8'h01, 1'b0, 8'h01, 1'b1},  // R3 mode 3
    {3'd6, 8'h02, 1'b0, 8'h01, 1'b0},  // R6 invalid 6
    {3'd7, 8'h00, 1'b1, 8'h21, 1'b0},  // R6 invalid 7
    {3'd5, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd5, 8'h01, 1'b0, 8'h01, 1'b1},  // R3 mode 5
    {3'd5, 8'hFE, 1'b0, 8'h02, 1'b0}   // R1 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state while held
    check("R8 rd in reset", 32'(rd_data), 32'h0);
    check("R8 restart in reset", 32'(ch2_restart), 32'h0);
    rst_n = 1'b1;
    check("R9 ready", 32'(wr_ready), 32'h1);

    // R7 first toggle P edges after release
    repeat (P - 1) @(negedge clk);
    check("R7 before first toggle", 32'(rd_data[4]), 32'h0);
    @(negedge clk);
    check("R7 first toggle", 32'(rd_data[4]), 32'h1);

    // vector walk
    for (int i = 0; i < 15; i++) begin
      ch2_mode = VEC[i][20:18];
      wr_data  = VEC[i][17:10];
      ch2_out  = VEC[i][9];
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      check($sformatf("R1/R2 vec%0d rd", i), 32'(rd_data & 8'hEF), 32'(VEC[i][8:1]));
      check($sformatf("R3/R4/R5/R6 vec%0d restart", i), 32'(ch2_restart), 32'(VEC[i][0]));
      @(negedge clk);
      check($sformatf("R3 vec%0d pulse end", i), 32'(ch2_restart), 32'h0);
    end

    // R2 ch2_out seen combinationally, no write
    ch2_out = 1'b1;
    #1;
    check("R2 out live", 32'(rd_data[5]), 32'h1);
    ch2_out = 1'b0;

    // R7 interval between two toggles
    begin
      logic last;
      int gap;
      last = rd_data[4];
      while (rd_data[4] == last) @(negedge clk);
      last = rd_data[4];
      gap = 0;
      while (rd_data[4] == last && gap < 3 * P) begin
        @(negedge clk);
        gap++;
      end
      check("R7 period", 32'(gap), 32'(P));
    end

    // R8 reset clears settings mid-run
    ch2_mode = 3'd2;
    wr_data  = 8'h03;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears", 32'(rd_data), 32'h0);
    check("R8 no restart", 32'(ch2_restart), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", 32'(rd_data & 8'hEF), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule